// File: doc/BRIEF.md
# Triangle-Count Complementary PWM Pair

The block holds a 16-bit counter that climbs from zero to a period value, falls back to zero, and repeats, so each full cycle spans twice the period in enabled clocks. Three compare registers are loaded through a plain strobe-and-data write port. The first register sets the period. The other two place the edges of two waveform legs meant to drive the high and low sides of an H-bridge.

Leg A toggles whenever the count equals its compare value and is forced low at the peak. Leg B toggles on its own compare value and is forced high at the peak. Set with 0 < compare A < compare B < period, leg B is high near the peak and leg A is high near the valley. Between them sits a gap of (compare B - compare A) timer clocks in which both legs are low. Each compare value also drives a match pulse. A sticky wrap flag marks every return of the count to zero.

The compare registers have no shadow copies. A write takes effect on the next clock, and software alone is responsible for keeping the dead gap safe while it changes them.

Top module: `updown_pwm_pair`

## Requirements
- R1: While run is high and the period P is nonzero, the count steps by one each clock in the order 0, 1, ..., P, P-1, ..., 1, 0, 1, .... The period match pulse therefore repeats every 2*P clocks.
- R2: Leg A toggles on the clock after the count equals compare A, and goes low on the clock after the count equals the period. The period match wins when both hit in the same clock.
- R3: Leg B toggles on the clock after the count equals compare B, and goes high on the clock after the count equals the period. The period match wins when both hit in the same clock.
- R4: With 0 < compare A < compare B < P held fixed, each interval with both legs low lasts exactly compare B - compare A clocks.
- R5: With 0 < compare A < compare B < P and no compare write since the legs were armed, leg A and leg B are never high together.
- R6: A write strobe (wr_sel bit 0 = period, bit 1 = compare A, bit 2 = compare B) loads wr_val on that clock edge. The next clock's matching already uses the new value.
- R7: The wrap flag is set on the clock edge where the count moves from a nonzero value to zero.
- R8: The wrap flag stays set until flag_clr is high at a clock edge. If a new wrap event arrives on the same edge as the clear, the flag stays set.
- R9: match bit n is high, combinationally, exactly while run is high and the count equals compare register n (bit 0 = period, bit 1 = A, bit 2 = B). With a nonzero period and no write to that register, it lasts one clock.
- R10: While run is low the count, direction, legs and flag hold, and all match bits are low.
- R11: After reset the count is 0, the direction is up, both legs and the flag are low, and all compare registers are 0. Matches on compare A and B leave the legs unchanged until the first period match after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable |
| wr_sel | input | 3 | Write strobes: bit 0 period, bit 1 compare A, bit 2 compare B |
| wr_val | input | 16 | Write data for the strobed registers |
| flag_clr | input | 1 | Clears the wrap flag |
| leg_a | output | 1 | Toggle/reset waveform leg |
| leg_b | output | 1 | Toggle/set waveform leg |
| match | output | 3 | Per-register equal-match pulses |
| wrap_flag | output | 1 | Sticky return-to-zero flag |

## Verification
The embedded properties check these on every clock: the count stays frozen while stopped, the count stays within the period, match pulses last one clock, the wrap flag follows its set and clear priority, and the legs never overlap under a valid ordering. Only the bench's scenarios can show some other behaviours. These are the exact triangle period, the measured width of the dead gap, the first-period arming after reset, and a mid-run compare write taking effect on the very next clock. The bench shows them by comparing every output with a behavioural model on every clock and by timing the edges it sees.

// File: rtl/updown_pwm_pair.sv
module updown_pwm_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_val,
  input  logic         flag_clr,
  output logic         leg_a,
  output logic         leg_b,
  output logic [2:0]   match,
  output logic         wrap_flag
);
  logic [W-1:0] cnt, cnt_nx, per, cmp_a, cmp_b;
  logic up, up_nx, armed, wrap_hit, wr_live;

  always_comb begin
    cnt_nx = cnt;
    up_nx  = up;
    if (up) begin
      if (cnt >= per) begin
        if (cnt != '0) begin
          up_nx  = 1'b0;
          cnt_nx = cnt - 1'b1;
        end
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        if (per != '0) begin
          up_nx  = 1'b1;
          cnt_nx = cnt + 1'b1;
        end
      end else begin
        cnt_nx = cnt - 1'b1;
      end
    end
  end

  assign match    = {3{run}} & {cnt == cmp_b, cnt == cmp_a, cnt == per};
  assign wrap_hit = run && (cnt != '0) && (cnt_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (run) begin
      cnt <= cnt_nx;
      up  <= up_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per   <= '0;
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (wr_sel[0]) per   <= wr_val;
      if (wr_sel[1]) cmp_a <= wr_val;
      if (wr_sel[2]) cmp_b <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      leg_a <= 1'b0;
      leg_b <= 1'b0;
    end else begin
      if (match[0]) begin
        armed <= 1'b1;
        leg_a <= 1'b0;
        leg_b <= 1'b1;
      end else if (armed) begin
        if (match[1]) leg_a <= ~leg_a;
        if (match[2]) leg_b <= ~leg_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wrap_flag <= 1'b0;
    else if (wrap_hit) wrap_flag <= 1'b1;
    else if (flag_clr) wrap_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wr_live <= 1'b0;
    else if (armed && |wr_sel)  wr_live <= 1'b1;
  end

  assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(up) && $stable(leg_a) && $stable(leg_b)));

  assert_no_match_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (match == 3'b000));

  assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= per) && (wr_sel == 3'b000) |=> (cnt <= per));

  assert_period_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] && (per != '0) && !wr_sel[0] |=> !match[0]);

  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> wrap_flag);

  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !wrap_hit |=> !wrap_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_flag && !flag_clr |=> wrap_flag);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wr_live && (cmp_a != '0) && (cmp_a < cmp_b) && (cmp_b < per)
      |-> !(leg_a && leg_b));
endmodule

// File: tb/test_updown_pwm_pair.sv
`timescale 1ns/1ps
module test_updown_pwm_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [2:0] wr_sel = 3'b000;
  logic [15:0] wr_val = '0;
  logic flag_clr = 1'b0;
  logic leg_a, leg_b, wrap_flag;
  logic [2:0] match;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  updown_pwm_pair i_updown_pwm_pair (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_sel(wr_sel), .wr_val(wr_val),
    .flag_clr(flag_clr), .leg_a(leg_a), .leg_b(leg_b), .match(match),
    .wrap_flag(wrap_flag)
  );

  always #2.5 clk = ~clk;

  int m_cnt, m_per, m_a, m_b;
  bit m_up, m_arm, m_la, m_lb, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_arm = 0; m_la = 0; m_lb = 0; m_flag = 0;
      m_per = 0; m_a = 0; m_b = 0;
    end else begin
      bit hit0, hita, hitb, wrap;
      int nxt;
      hit0 = run && m_cnt == m_per;
      hita = run && m_cnt == m_a;
      hitb = run && m_cnt == m_b;
      nxt = m_cnt;
      wrap = 0;
      if (run) begin
        if (m_up) begin
          if (m_cnt < m_per) nxt = m_cnt + 1;
          else if (m_cnt > 0) begin nxt = m_cnt - 1; m_up = 0; end
        end else begin
          if (m_cnt > 0) nxt = m_cnt - 1;
          else if (m_per > 0) begin nxt = 1; m_up = 1; end
        end
        wrap = (m_cnt != 0) && (nxt == 0);
      end
      m_cnt = nxt;
      if (hit0) begin m_arm = 1; m_la = 0; m_lb = 1; end
      else if (m_arm) begin
        if (hita) m_la = !m_la;
        if (hitb) m_lb = !m_lb;
      end
      if (wrap) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (wr_sel[0]) m_per = wr_val;
      if (wr_sel[1]) m_a = wr_val;
      if (wr_sel[2]) m_b = wr_val;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  bit gap_on = 0, per_on = 0, in_gap = 0, prev_lb = 0;
  int gap_len = 0, cyc = 0, last_p = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] em;
      cyc++;
      em = {run && m_cnt == m_b, run && m_cnt == m_a, run && m_cnt == m_per};
      check(leg_a == m_la, "R2 leg_a", leg_a, m_la);
      check(leg_b == m_lb, "R3 leg_b", leg_b, m_lb);
      check(match == em, "R9 match", match, em);
      check(wrap_flag == m_flag, "R7 wrap_flag", wrap_flag, m_flag);
      if (gap_on) begin
        check(!(leg_a && leg_b), "R5 overlap", leg_a & leg_b, 0);
        if (prev_lb && !leg_b && !leg_a) begin in_gap = 1; gap_len = 0; end
        if (in_gap) begin
          if (leg_a) begin
            check(gap_len == m_b - m_a, "R4 dead gap", gap_len, m_b - m_a);
            in_gap = 0;
          end else gap_len++;
        end
      end else in_gap = 0;
      if (per_on && match[0]) begin
        if (last_p >= 0) check(cyc - last_p == 2 * m_per, "R1 period", cyc - last_p, 2 * m_per);
        last_p = cyc;
      end
      prev_lb = leg_b;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input int sel, input int val);
    wr_sel = sel[2:0]; wr_val = val[15:0];
    step(1);
    wr_sel = 3'b000;
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    check(leg_a == 0 && leg_b == 0 && wrap_flag == 0, "R11 reset outputs", {leg_a, leg_b, wrap_flag}, 0);
    check(match == 3'b000, "R11 reset match", match, 0);
    wr(1, 20); wr(2, 5); wr(4, 9);
    // R10 stopped: nothing moves
    step(5);
    check(match == 3'b000 && leg_a == 0, "R10 stopped", {match, leg_a}, 0);
    run = 1'b1;
    // R11 legs frozen during first climb past A and B
    step(12);
    check(leg_a == 0 && leg_b == 0, "R11 unarmed legs", {leg_a, leg_b}, 0);
    gap_on = 1; per_on = 1;
    step(150);
    per_on = 0;
    // R10 pause mid-run
    run = 1'b0;
    step(7);
    check(match == 3'b000, "R10 paused match", match, 0);
    run = 1'b1;
    step(60);
    // R8 clear coincident with wrap event
    do step(1); while (!(m_cnt == 1 && !m_up));
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check(wrap_flag == 1, "R8 set wins over clear", wrap_flag, 1);
    step(2);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check(wrap_flag == 0, "R8 clear", wrap_flag, 0);
    // R6 unbuffered write
    do step(1); while (!(m_up && m_cnt > 0 && m_cnt + 3 < m_per));
    gap_on = 0;
    wr_sel = 3'b010; wr_val = 16'(m_cnt + 1);
    step(1);
    wr_sel = 3'b000;
    check(match[1] == 1, "R6 new compare A", match[1], 1);
    step(40);
    // R1 with a shorter period and new dead gap
    wr(1, 12); wr(2, 3); wr(4, 8);
    step(30);
    per_on = 1; last_p = -1; gap_on = 1;
    step(100);
    run = 1'b0;
    step(2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule